// File: doc/BRIEF.md
# Unprivileged Vector Load-Pair Sequencer

This block takes one 32-bit load-pair instruction word that fills two 128-bit vector registers and carries out the memory part of it. It decodes the addressing form, builds the effective address from a 64-bit base and a signed immediate scaled by 16, and reads the two data words over a request/response memory port. It then presents both data words with their destination register numbers in a single completion cycle. When the form calls for it, it also presents the base-register writeback value.

The sequencer runs as either one double-width 32-byte read or two 16-byte reads, chosen by a feature input. It drives a tag-check-required flag for the memory system. The block reports undefined, no-op, trap and alignment-fault outcomes in place of an access. The register file, the memory, translation and privilege checks sit outside it.

Top module: `pairload_seq`

## Requirements
- R1: Bits 31:22 select the form: 1110110011 is post-index, 1110110111 is pre-index, 1110110101 is signed offset without writeback. Any other pattern raises flagUndef at completion and issues no memory request.
- R2: Fields: imm7 = bits 21:15, second destination = bits 14:10, base = bits 9:5, first destination = bits 4:0. The byte offset is imm7 sign-extended and multiplied by 16, covering -1024 to +1008. dest1/dest2 report the destination fields at completion.
- R3: Post-index reads at the unmodified base. Pre-index and signed offset read at base+offset (modulo 2^64). wbValue is base+offset. wbValid is 1 at completion only for post-index and pre-index, and only when no fault is raised.
- R4: A base field of 31 takes the base from baseSp, otherwise from baseGpr, and wbToSp reports this. tagCheck is 1 when the form writes back or the base field is not 31.
- R5: With a base field of 31 and baseSp[3:0] not zero, flagAlign is raised, no request is issued and wbValid stays 0.
- R6: With pairMode=1 one request with memReqSize=1 (32 bytes) is issued. With bigEndian=0, dataOut1 takes response bits 127:0 and dataOut2 takes bits 255:128. With bigEndian=1 the halves are swapped.
- R7: With pairMode=0 two requests with memReqSize=0 (16 bytes) are issued, first at the address and then at the address plus 16. dataOut1 and dataOut2 take response bits 127:0 of the first and second responses. bigEndian has no effect in this mode.
- R8: When both destination fields are equal, overlapPolicy decides the outcome: 0 or 3 raises flagUndef, 1 raises flagNop, and 2 completes the reads with dataOut1 and dataOut2 both all ones. flagUndef and flagNop issue no request.
- R9: featFp=0 or featUnpriv=0 raises flagUndef with no request. Otherwise fpEnable=0 raises flagTrap with no request. Priority is: undefined (form or feature), then the equal-destination undefined/no-op, then trap, then alignment.
- R10: memReqValid, memReqAddr and memReqSize hold until memReqReady is seen. A response is taken on memRspValid, and only one request is outstanding at a time.
- R11: Completion is done=1 for exactly one cycle. The flags, the data outputs and the writeback outputs are valid in that cycle, at most one flag is set, and a raised flag forces wbValid to 0. dataOut1 and dataOut2 are 0 when no read is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an instruction (taken when idle) |
| instr | input | 32 | Instruction word, held until done |
| baseGpr | input | 64 | General register base value |
| baseSp | input | 64 | Stack pointer base value |
| featFp | input | 1 | Floating-point feature present |
| featUnpriv | input | 1 | Unprivileged-load feature present |
| fpEnable | input | 1 | Floating-point access enabled |
| pairMode | input | 1 | 1: single 32-byte access |
| bigEndian | input | 1 | Data endianness for the 32-byte access |
| overlapPolicy | input | 2 | Outcome for equal destinations |
| memReqValid | output | 1 | Read request valid |
| memReqReady | input | 1 | Read request accepted |
| memReqAddr | output | 64 | Read byte address |
| memReqSize | output | 1 | 0: 16 bytes, 1: 32 bytes |
| memRspValid | input | 1 | Read data valid |
| memRspData | input | 256 | Read data |
| done | output | 1 | Completion strobe |
| flagUndef | output | 1 | Undefined instruction |
| flagTrap | output | 1 | Floating-point trap |
| flagNop | output | 1 | Completed as no-op |
| flagAlign | output | 1 | Stack pointer alignment fault |
| tagCheck | output | 1 | Tag check required |
| dest1 | output | 5 | First destination register |
| dest2 | output | 5 | Second destination register |
| dataOut1 | output | 128 | Data for first destination |
| dataOut2 | output | 128 | Data for second destination |
| wbValid | output | 1 | Base writeback required |
| wbToSp | output | 1 | Writeback target is the stack pointer |
| wbValue | output | 64 | Base writeback value |

## Verification
The hardest cases to reach are the ones where two outcomes compete in the same instruction. Examples are an equal-destination no-op with the floating-point enable off, or a trap together with a misaligned stack pointer, where only the priority decides which single flag appears. The bench builds these directly from instruction fields and control inputs, and sweeps every form against several immediates, three base situations, both access modes and both endiannesses. The bench memory answers with data computed from the request address and varies its handshake latency. This lets each data word be traced back to the address that produced it, and shows up any swapped halves or a wrong second address.

// File: rtl/pairload_pkg.sv
package pairload_pkg;
  localparam logic [9:0] FORM_POST = 10'b1110110011;
  localparam logic [9:0] FORM_PRE  = 10'b1110110111;
  localparam logic [9:0] FORM_OFF  = 10'b1110110101;

  localparam logic [1:0] OVL_UNDEF = 2'd0;
  localparam logic [1:0] OVL_NOP   = 2'd1;
  localparam logic [1:0] OVL_ONES  = 2'd2;

  typedef enum logic [2:0] {
    ST_IDLE, ST_REQ1, ST_WAIT1, ST_REQ2, ST_WAIT2, ST_DONE
  } seqState_t;

  typedef struct packed {
    logic undef;
    logic nop;
    logic trap;
    logic align;
  } faults_t;

  typedef struct packed {
    logic loadOp;
    logic capFirst;
    logic capSecond;
    logic capBoth;
    logic secondAddr;
  } dpStrobe_t;
endpackage

// File: rtl/pairload_decode.sv
module pairload_decode
  import pairload_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int DATA_W = 128
) (
  input  logic [31:0]       instr,
  input  logic [ADDR_W-1:0] baseGpr,
  input  logic [ADDR_W-1:0] baseSp,
  input  logic              featFp,
  input  logic              featUnpriv,
  input  logic              fpEnable,
  input  logic [1:0]        overlapPolicy,
  output logic [ADDR_W-1:0] accAddr,
  output logic [ADDR_W-1:0] wbAddr,
  output logic              wbEn,
  output logic              tagReq,
  output logic              useSp,
  output logic [4:0]        rt1,
  output logic [4:0]        rt2,
  output faults_t           faults,
  output logic              forceOnes,
  output logic              abort
);
  localparam int IMM_W = 7;
  localparam int SCALE = $clog2(DATA_W / 8);
  localparam int EXT_W = ADDR_W - IMM_W - SCALE;

  logic [9:0]        opcode;
  logic [IMM_W-1:0]  imm;
  logic [4:0]        rn;
  logic              isPost, isPre, isOff, formOk, sameDest, badFeat;
  logic [ADDR_W-1:0] offset, base, sum;

  always_comb begin
    opcode  = instr[31:22];
    imm     = instr[21:15];
    rt2     = instr[14:10];
    rn      = instr[9:5];
    rt1     = instr[4:0];
    isPost  = opcode == FORM_POST;
    isPre   = opcode == FORM_PRE;
    isOff   = opcode == FORM_OFF;
    formOk  = isPost | isPre | isOff;
    wbEn    = isPost | isPre;
    useSp   = rn == 5'd31;
    offset  = {{EXT_W{imm[IMM_W-1]}}, imm, {SCALE{1'b0}}};
    base    = useSp ? baseSp : baseGpr;
    sum     = base + offset;
    accAddr = isPost ? base : sum;
    wbAddr  = sum;
    tagReq  = wbEn | ~useSp;

    sameDest = rt1 == rt2;
    badFeat  = ~formOk | ~featFp | ~featUnpriv;
    faults.undef = badFeat | (sameDest & (overlapPolicy != OVL_NOP) & (overlapPolicy != OVL_ONES));
    faults.nop   = ~faults.undef & sameDest & (overlapPolicy == OVL_NOP);
    faults.trap  = ~faults.undef & ~faults.nop & ~fpEnable;
    faults.align = ~faults.undef & ~faults.nop & ~faults.trap & useSp & (|base[SCALE-1:0]);
    abort     = |faults;
    forceOnes = sameDest & (overlapPolicy == OVL_ONES) & ~abort;
  end
endmodule

// File: rtl/pairload_ctrl.sv
module pairload_ctrl
  import pairload_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      start,
  input  logic      abort,
  input  logic      pairQ,
  input  logic      memReqReady,
  input  logic      memRspValid,
  output dpStrobe_t strobe,
  output logic      memReqValid,
  output logic      done
);
  seqState_t state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState   = state;
    strobe      = '0;
    memReqValid = 1'b0;
    done        = 1'b0;
    case (state)
      ST_IDLE: if (start) begin
        strobe.loadOp = 1'b1;
        nextState     = abort ? ST_DONE : ST_REQ1;
      end
      ST_REQ1: begin
        memReqValid = 1'b1;
        if (memReqReady) nextState = ST_WAIT1;
      end
      ST_WAIT1: if (memRspValid) begin
        if (pairQ) begin
          strobe.capBoth = 1'b1;
          nextState      = ST_DONE;
        end else begin
          strobe.capFirst = 1'b1;
          nextState       = ST_REQ2;
        end
      end
      ST_REQ2: begin
        memReqValid       = 1'b1;
        strobe.secondAddr = 1'b1;
        if (memReqReady) nextState = ST_WAIT2;
      end
      ST_WAIT2: if (memRspValid) begin
        strobe.capSecond = 1'b1;
        nextState        = ST_DONE;
      end
      ST_DONE: begin
        done      = 1'b1;
        nextState = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end
endmodule

// File: rtl/pairload_dp.sv
module pairload_dp
  import pairload_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int DATA_W = 128
) (
  input  logic                clk,
  input  logic                rstN,
  input  dpStrobe_t           strobe,
  input  logic                done,
  input  logic [ADDR_W-1:0]   accAddr,
  input  logic [ADDR_W-1:0]   wbAddr,
  input  logic                wbEn,
  input  logic                tagReq,
  input  logic                useSp,
  input  logic [4:0]          rt1,
  input  logic [4:0]          rt2,
  input  faults_t             faults,
  input  logic                forceOnes,
  input  logic                pairMode,
  input  logic                bigEndian,
  input  logic [2*DATA_W-1:0] memRspData,
  output logic                pairQ,
  output logic [ADDR_W-1:0]   memReqAddr,
  output logic                memReqSize,
  output logic                flagUndef,
  output logic                flagTrap,
  output logic                flagNop,
  output logic                flagAlign,
  output logic                tagCheck,
  output logic [4:0]          dest1,
  output logic [4:0]          dest2,
  output logic [DATA_W-1:0]   dataOut1,
  output logic [DATA_W-1:0]   dataOut2,
  output logic                wbValid,
  output logic                wbToSp,
  output logic [ADDR_W-1:0]   wbValue
);
  localparam int BYTES = DATA_W / 8;

  logic [ADDR_W-1:0] accQ, wbQ;
  logic              wbEnQ, onesQ, bigQ;
  faults_t           faultQ;
  logic [DATA_W-1:0] d1Q, d2Q;
  logic [DATA_W-1:0] rspLo, rspHi;

  assign rspLo = memRspData[DATA_W-1:0];
  assign rspHi = memRspData[2*DATA_W-1:DATA_W];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      accQ <= '0; wbQ <= '0; wbEnQ <= 1'b0; onesQ <= 1'b0; bigQ <= 1'b0;
      pairQ <= 1'b0; faultQ <= '0; tagCheck <= 1'b0; wbToSp <= 1'b0;
      dest1 <= '0; dest2 <= '0; d1Q <= '0; d2Q <= '0;
    end else if (strobe.loadOp) begin
      accQ <= accAddr; wbQ <= wbAddr; wbEnQ <= wbEn; onesQ <= forceOnes;
      bigQ <= bigEndian; pairQ <= pairMode; faultQ <= faults;
      tagCheck <= tagReq; wbToSp <= useSp; dest1 <= rt1; dest2 <= rt2;
      d1Q <= '0; d2Q <= '0;
    end else begin
      if (strobe.capFirst) d1Q <= rspLo;
      if (strobe.capSecond) d2Q <= rspLo;
      if (strobe.capBoth) begin
        d1Q <= bigQ ? rspHi : rspLo;
        d2Q <= bigQ ? rspLo : rspHi;
      end
    end
  end

  always_comb begin
    memReqAddr = strobe.secondAddr ? accQ + ADDR_W'(BYTES) : accQ;
    memReqSize = pairQ & ~strobe.secondAddr;
    flagUndef  = done & faultQ.undef;
    flagTrap   = done & faultQ.trap;
    flagNop    = done & faultQ.nop;
    flagAlign  = done & faultQ.align;
    wbValid    = done & wbEnQ & ~(|faultQ);
    wbValue    = wbQ;
    dataOut1   = onesQ ? '1 : d1Q;
    dataOut2   = onesQ ? '1 : d2Q;
  end
endmodule

// File: rtl/pairload_seq.sv
module pairload_seq
  import pairload_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int DATA_W = 128
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                start,
  input  logic [31:0]         instr,
  input  logic [ADDR_W-1:0]   baseGpr,
  input  logic [ADDR_W-1:0]   baseSp,
  input  logic                featFp,
  input  logic                featUnpriv,
  input  logic                fpEnable,
  input  logic                pairMode,
  input  logic                bigEndian,
  input  logic [1:0]          overlapPolicy,
  output logic                memReqValid,
  input  logic                memReqReady,
  output logic [ADDR_W-1:0]   memReqAddr,
  output logic                memReqSize,
  input  logic                memRspValid,
  input  logic [2*DATA_W-1:0] memRspData,
  output logic                done,
  output logic                flagUndef,
  output logic                flagTrap,
  output logic                flagNop,
  output logic                flagAlign,
  output logic                tagCheck,
  output logic [4:0]          dest1,
  output logic [4:0]          dest2,
  output logic [DATA_W-1:0]   dataOut1,
  output logic [DATA_W-1:0]   dataOut2,
  output logic                wbValid,
  output logic                wbToSp,
  output logic [ADDR_W-1:0]   wbValue
);
  logic [ADDR_W-1:0] accAddr, wbAddr;
  logic              wbEn, tagReq, useSp, forceOnes, abort, pairQ;
  logic [4:0]        rt1, rt2;
  faults_t           faults;
  dpStrobe_t         strobe;

  pairload_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uDecode (
    .instr(instr), .baseGpr(baseGpr), .baseSp(baseSp), .featFp(featFp),
    .featUnpriv(featUnpriv), .fpEnable(fpEnable), .overlapPolicy(overlapPolicy),
    .accAddr(accAddr), .wbAddr(wbAddr), .wbEn(wbEn), .tagReq(tagReq),
    .useSp(useSp), .rt1(rt1), .rt2(rt2), .faults(faults),
    .forceOnes(forceOnes), .abort(abort)
  );

  pairload_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .abort(abort), .pairQ(pairQ),
    .memReqReady(memReqReady), .memRspValid(memRspValid), .strobe(strobe),
    .memReqValid(memReqValid), .done(done)
  );

  pairload_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .done(done), .accAddr(accAddr),
    .wbAddr(wbAddr), .wbEn(wbEn), .tagReq(tagReq), .useSp(useSp), .rt1(rt1),
    .rt2(rt2), .faults(faults), .forceOnes(forceOnes), .pairMode(pairMode),
    .bigEndian(bigEndian), .memRspData(memRspData), .pairQ(pairQ),
    .memReqAddr(memReqAddr), .memReqSize(memReqSize), .flagUndef(flagUndef),
    .flagTrap(flagTrap), .flagNop(flagNop), .flagAlign(flagAlign),
    .tagCheck(tagCheck), .dest1(dest1), .dest2(dest2), .dataOut1(dataOut1),
    .dataOut2(dataOut2), .wbValid(wbValid), .wbToSp(wbToSp), .wbValue(wbValue)
  );
endmodule

// File: rtl/pairload_checker.sv
module pairload_checker #(
  parameter int ADDR_W = 64
) (
  input logic              clk,
  input logic              rstN,
  input logic              memReqValid,
  input logic              memReqReady,
  input logic [ADDR_W-1:0] memReqAddr,
  input logic              memReqSize,
  input logic              done,
  input logic              flagUndef,
  input logic              flagTrap,
  input logic              flagNop,
  input logic              flagAlign,
  input logic              wbValid
);
  a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  a_r10_req_hold: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && !memReqReady |=> memReqValid && $stable(memReqAddr) && $stable(memReqSize));

  a_r10_no_req_at_done: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !memReqValid);

  a_r11_flags_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({flagUndef, flagTrap, flagNop, flagAlign}));

  a_r11_fault_no_wb: assert property (@(posedge clk) disable iff (!rstN)
    (flagUndef || flagTrap || flagNop || flagAlign) |-> !wbValid);

  a_r3_wb_at_done: assert property (@(posedge clk) disable iff (!rstN)
    wbValid |-> done);

  a_r5_flag_at_done: assert property (@(posedge clk) disable iff (!rstN)
    flagAlign |-> done && !memReqValid);
endmodule

bind pairload_seq pairload_checker #(.ADDR_W(ADDR_W)) uChecker (.*);

// File: tb/pairload_seq_test.sv
`timescale 1ns/1ps
module pairload_seq_test;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         start = 1'b0;
  logic [31:0]  instr = '0;
  logic [63:0]  baseGpr = '0, baseSp = '0;
  logic         featFp = 1'b1, featUnpriv = 1'b1, fpEnable = 1'b1;
  logic         pairMode = 1'b0, bigEndian = 1'b0;
  logic [1:0]   overlapPolicy = 2'd0;
  logic         memReqValid, memReqReady = 1'b0, memReqSize;
  logic [63:0]  memReqAddr;
  logic         memRspValid = 1'b0;
  logic [255:0] memRspData = '0;
  logic         done, flagUndef, flagTrap, flagNop, flagAlign, tagCheck;
  logic [4:0]   dest1, dest2;
  logic [127:0] dataOut1, dataOut2;
  logic         wbValid, wbToSp;
  logic [63:0]  wbValue;

  int errors = 0, checks = 0;
  int lat = 0;
  int reqCount = 0;
  logic [63:0] reqAddr [0:3];
  logic        reqSize [0:3];

  always #2 clk = ~clk;

  pairload_seq uut (.*);

  function automatic logic [127:0] pat(input logic [63:0] a);
    return {a ^ 64'hA5C3_0F96_1E2D_7B48, ~a};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (memReqValid) begin
        repeat (lat) @(negedge clk);
        if (reqCount < 4) begin
          reqAddr[reqCount] = memReqAddr;
          reqSize[reqCount] = memReqSize;
        end
        reqCount++;
        memReqReady = 1'b1;
        @(negedge clk);
        memReqReady = 1'b0;
        repeat (lat) @(negedge clk);
        if (reqSize[(reqCount - 1) % 4])
          memRspData = {pat(reqAddr[(reqCount - 1) % 4] + 64'd16), pat(reqAddr[(reqCount - 1) % 4])};
        else
          memRspData = {128'hDEAD_BEEF_0BAD_F00D_1234_5678_9ABC_DEF0, pat(reqAddr[(reqCount - 1) % 4])};
        memRspValid = 1'b1;
        @(negedge clk);
        memRspValid = 1'b0;
      end
    end
  end

  task automatic runOne(input logic [9:0] form, input logic [6:0] imm, input logic [4:0] r1,
                        input logic [4:0] r2, input logic [4:0] rn);
    logic [63:0] base, off, acc, sumv;
    bit postF, preF, offF, formOk, same, eUndef, eNop, eTrap, eAlign, exec, wbE, useSp;
    logic [127:0] e1, e2;
    int expReqs, t;
    postF = form == 10'b1110110011;
    preF  = form == 10'b1110110111;
    offF  = form == 10'b1110110101;
    formOk = postF || preF || offF;
    wbE = postF || preF;
    useSp = rn == 5'd31;
    base = useSp ? baseSp : baseGpr;
    off = 64'($signed(imm) * 16);
    sumv = base + off;
    acc = postF ? base : sumv;
    same = r1 == r2;
    eUndef = !formOk || !featFp || !featUnpriv || (same && (overlapPolicy == 2'd0 || overlapPolicy == 2'd3));
    eNop   = !eUndef && same && overlapPolicy == 2'd1;
    eTrap  = !eUndef && !eNop && !fpEnable;
    eAlign = !eUndef && !eNop && !eTrap && useSp && (base % 16 != 0);
    exec = !(eUndef || eNop || eTrap || eAlign);
    expReqs = !exec ? 0 : (pairMode ? 1 : 2);
    if (!exec) begin e1 = '0; e2 = '0; end
    else if (same) begin e1 = '1; e2 = '1; end
    else if (pairMode && bigEndian) begin e1 = pat(acc + 64'd16); e2 = pat(acc); end
    else begin e1 = pat(acc); e2 = pat(acc + 64'd16); end

    reqCount = 0;
    @(negedge clk);
    instr = {form, imm, r2, rn, r1};
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    t = 0;
    while (!done && t < 200) begin @(negedge clk); t++; end
    check(done == 1'b1, "R11 done", 128'(done), 128'd1);
    check(flagUndef == eUndef, "R1 R8 R9 undef", 128'(flagUndef), 128'(eUndef));
    check(flagNop == eNop, "R8 nop", 128'(flagNop), 128'(eNop));
    check(flagTrap == eTrap, "R9 trap", 128'(flagTrap), 128'(eTrap));
    check(flagAlign == eAlign, "R5 align", 128'(flagAlign), 128'(eAlign));
    check(reqCount == expReqs, "R5 R6 R7 R9 request count", 128'(reqCount), 128'(expReqs));
    if (expReqs >= 1) begin
      check(reqAddr[0] == acc, "R3 first address", 128'(reqAddr[0]), 128'(acc));
      check(reqSize[0] == pairMode, "R6 R7 size", 128'(reqSize[0]), 128'(pairMode));
    end
    if (expReqs == 2) begin
      check(reqAddr[1] == acc + 64'd16, "R7 second address", 128'(reqAddr[1]), 128'(acc + 64'd16));
      check(reqSize[1] == 1'b0, "R7 second size", 128'(reqSize[1]), 128'd0);
    end
    check(dataOut1 == e1, "R6 R7 R8 R11 data1", dataOut1, e1);
    check(dataOut2 == e2, "R6 R7 R8 R11 data2", dataOut2, e2);
    check(dest1 == r1 && dest2 == r2, "R2 dests", 128'({dest1, dest2}), 128'({r1, r2}));
    check(wbValid == (exec && wbE), "R3 R11 wbValid", 128'(wbValid), 128'(exec && wbE));
    if (exec && wbE) begin
      check(wbValue == sumv, "R3 wbValue", 128'(wbValue), 128'(sumv));
      check(wbToSp == useSp, "R4 wbToSp", 128'(wbToSp), 128'(useSp));
    end
    if (formOk) check(tagCheck == (wbE || !useSp), "R4 tagCheck", 128'(tagCheck), 128'(wbE || !useSp));
    @(negedge clk);
    check(done == 1'b0, "R11 single cycle", 128'(done), 128'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [9:0] forms [0:3];
    logic [6:0] imms [0:4];
    forms[0] = 10'b1110110011; forms[1] = 10'b1110110111;
    forms[2] = 10'b1110110101; forms[3] = 10'b1110110001;
    imms[0] = 7'd0; imms[1] = 7'd1; imms[2] = 7'd63; imms[3] = 7'd64; imms[4] = 7'd127;
    repeat (3) @(negedge clk);
    check(done == 0 && memReqValid == 0 && wbValid == 0, "R11 reset state",
          128'({done, memReqValid, wbValid}), 128'd0);
    rstN = 1'b1;
    // R1 R2 R3 R4 R5 R6 R7 sweep
    for (int f = 0; f < 4; f++)
      for (int i = 0; i < 5; i++)
        for (int b = 0; b < 3; b++)
          for (int m = 0; m < 4; m++) begin
            pairMode = m[0];
            bigEndian = m[1];
            lat = (f + i + b + m) % 3;
            baseGpr = 64'h0000_1234_5678_9A00 + 64'(i * 48);
            baseSp  = (b == 2) ? 64'h0000_7FFF_0000_1008 : 64'h0000_7FFF_0000_1000 - 64'(i * 16);
            if (i == 4 && b == 0) baseGpr = 64'h0000_0000_0000_0100;
            runOne(forms[f], imms[i], 5'd5, 5'd17, (b == 0) ? 5'd3 : 5'd31);
          end
    pairMode = 1'b0; bigEndian = 1'b0; lat = 1;
    baseGpr = 64'hFFFF_FFFF_FFFF_FFF0;
    // R3 address wraps modulo 2^64
    runOne(forms[1], 7'd2, 5'd1, 5'd2, 5'd4);
    // R8 equal destinations, each policy, both modes
    for (int p = 0; p < 4; p++)
      for (int m = 0; m < 2; m++) begin
        overlapPolicy = 2'(p);
        pairMode = m[0];
        runOne(forms[0], 7'd3, 5'd9, 5'd9, 5'd7);
      end
    overlapPolicy = 2'd0; pairMode = 1'b1;
    // R9 feature and enable inputs
    featFp = 1'b0; runOne(forms[1], 7'd1, 5'd1, 5'd2, 5'd3); featFp = 1'b1;
    featUnpriv = 1'b0; runOne(forms[2], 7'd1, 5'd1, 5'd2, 5'd3); featUnpriv = 1'b1;
    fpEnable = 1'b0; runOne(forms[0], 7'd1, 5'd1, 5'd2, 5'd3);
    // R9 priority: trap over misaligned stack pointer
    baseSp = 64'h0000_0000_0000_2004;
    runOne(forms[1], 7'd1, 5'd1, 5'd2, 5'd31);
    // R9 priority: equal-destination no-op over trap
    overlapPolicy = 2'd1;
    runOne(forms[1], 7'd1, 5'd6, 5'd6, 5'd2);
    fpEnable = 1'b1; overlapPolicy = 2'd0;
    // R10 long handshake latency
    lat = 5; pairMode = 1'b0;
    runOne(forms[2], 7'd120, 5'd11, 5'd12, 5'd8);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule